// File: doc/BRIEF.md
# Energize-Then-Hold Output Sequencer

This block sequences a bank of low-side gate enables that share a single 8-bit control byte. When a channel's on-bit goes high, the gate is held fully on for a programmed energizing time. The gate then settles into a hold behaviour that the same byte selects. It can chop at a duty cycle set in eighths, switch off, or stay fully on when the timer is disabled. The hold phase saves power in relays, solenoids and stepper windings that need a high pull-in current but only a modest holding current.

A one-cycle early-exit pulse cuts short the energizing phase of every channel that is still in it. A global output-enable input and a per-channel fault input can force gates low. One prescaler derives a chopping slot clock (nominally 400 kHz) and a millisecond tick from the system clock, and every channel shares the same slot counter.

Top module: `hold_pwm_seq`

## Requirements
- R1: After reset every gate is low, and any channel whose on-bit is 0 at a clock edge has its gate low from that edge on.
- R2: With control bit 7 (timer enable) at 0, a channel whose on-bit is 1 drives its gate high continuously, whatever the other control bits hold.
- R3: With bit 7 at 1 and energize code bits 3:0 non-zero, a rising on-bit starts a gate-high phase. That phase lasts T milliseconds, counted in prescaler ms ticks so that the real duration lies in (T-1, T] ms. T comes from the code 1..15 as 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260, 300.
- R4: With bit 7 at 1 and energize code 0, a rising on-bit places the channel straight in the hold phase.
- R5: In the hold phase with duty code k in bits 6:4, the gate is high k/8 of the time; k = 0 keeps the gate low.
- R6: Chopping runs in slots of SLOT_HZ. The chop period is 8 slots for k >= 3, 16 slots for k = 2, and 32 slots for k = 1, which gives 50, 25 and 12.5 kHz at the default rate.
- R7: A one-cycle pwm_start pulse moves any channel that is energizing into the hold phase at the next edge.
- R8: A pwm_start pulse arriving after a channel has reached the hold phase leaves its chopping unchanged.
- R9: Every 0-to-1 transition of an on-bit restarts that channel's energizing timer from zero.
- R10: out_en low forces all gates low in the same cycle, without waiting for a clock edge.
- R11: A fault pulse on an active channel drives its gate low from the next edge. The gate stays low after the fault input clears, until the on-bit is taken to 0 and raised again.
- R12: Each channel keeps its own phase and timer, so channels raised at different times expire at different times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reg | input | 8 | Bit 7 timer enable, bits 6:4 hold duty in eighths, bits 3:0 energize code |
| chan_on | input | NCH | Per-channel on request |
| pwm_start | input | 1 | One-cycle early exit from energizing |
| out_en | input | 1 | Global output enable, low forces all gates off |
| fault | input | NCH | Per-channel fault pulse, latched as a forced-off state |
| gate | output | NCH | Gate enables |

## Verification
The hardest situation to produce is the boundary around the end of energizing, because the ms tick runs freely and is not aligned with the moment a channel is raised. The stimulus therefore checks only windows that hold for any tick phase: it expects the gate high over T-1 ms of edges and low a little after T ms. Duty and chop period are measured as counts of high samples and of rising transitions over a window that spans whole periods, so the result does not depend on where the window starts. The early-exit rule is tested on both sides: once during a long energize and once after expiry, where a re-energize would show up as a full-on window.

// File: rtl/hpwm_pkg.sv
package hpwm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ENER = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic       tmr_en;
        logic [2:0] duty;
        logic [3:0] ener_code;
    } ctl_t;

    localparam int SLOT_W = 5;
    localparam int MS_CW  = 9;

    // energizing time in ms for each code
    function automatic logic [MS_CW-1:0] ener_ms(input logic [3:0] code);
        case (code)
            4'd0:    ener_ms = 9'd0;
            4'd1:    ener_ms = 9'd3;
            4'd2:    ener_ms = 9'd5;
            4'd3:    ener_ms = 9'd10;
            4'd4:    ener_ms = 9'd15;
            4'd5:    ener_ms = 9'd20;
            4'd6:    ener_ms = 9'd30;
            4'd7:    ener_ms = 9'd50;
            4'd8:    ener_ms = 9'd80;
            4'd9:    ener_ms = 9'd110;
            4'd10:   ener_ms = 9'd140;
            4'd11:   ener_ms = 9'd170;
            4'd12:   ener_ms = 9'd200;
            4'd13:   ener_ms = 9'd230;
            4'd14:   ener_ms = 9'd260;
            default: ener_ms = 9'd300;
        endcase
    endfunction

    // chop pattern: 4 slots on out of 32 / 16, or duty out of 8
    function automatic logic hold_on(input logic [2:0] duty, input logic [SLOT_W-1:0] slot);
        case (duty)
            3'd0:    hold_on = 1'b0;
            3'd1:    hold_on = (slot < 5'd4);
            3'd2:    hold_on = (slot[3:0] < 4'd4);
            default: hold_on = (slot[2:0] < duty);
        endcase
    endfunction

endpackage

// File: rtl/hpwm_tick.sv
module hpwm_tick
    import hpwm_pkg::*;
#(
    parameter int SLOT_DIV = 250,
    parameter int MS_SLOTS = 400
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ms_tick,
    output logic [SLOT_W-1:0] slot
);
    localparam int DIV_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;
    localparam int MSS_W = (MS_SLOTS > 1) ? $clog2(MS_SLOTS) : 1;

    logic [DIV_W-1:0] div_q;
    logic [MSS_W-1:0] ms_q;
    logic             slot_tick;

    assign slot_tick = (div_q == DIV_W'(SLOT_DIV - 1));
    assign ms_tick   = slot_tick && (ms_q == MSS_W'(MS_SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            ms_q  <= '0;
            slot  <= '0;
        end else if (slot_tick) begin
            div_q <= '0;
            slot  <= slot + 1'b1;
            ms_q  <= (ms_q == MSS_W'(MS_SLOTS - 1)) ? '0 : ms_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R6: the shared slot counter advances by one per slot tick
    a_r6_slot_step: assert property (@(posedge clk) disable iff (rst)
        slot_tick |=> (slot == $past(slot) + 5'd1));

    // R6: between slot ticks the counter does not move
    a_r6_slot_hold: assert property (@(posedge clk) disable iff (rst)
        !slot_tick |=> $stable(slot));

endmodule

// File: rtl/hpwm_chan.sv
module hpwm_chan
    import hpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              data,
    input  logic              pwm_start,
    input  logic              ms_tick,
    input  logic [SLOT_W-1:0] slot,
    input  logic              fault,
    output logic              gate
);
    phase_e           phase;
    logic [MS_CW-1:0] cnt;
    logic             killed;
    logic [MS_CW-1:0] limit;

    assign limit = ener_ms(ctl.ener_code);

    always_ff @(posedge clk) begin
        if (rst || !data) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            killed <= 1'b0;
        end else if (phase == PH_IDLE) begin
            cnt    <= '0;
            killed <= fault;
            phase  <= (ctl.ener_code == 4'd0) ? PH_HOLD : PH_ENER;
        end else begin
            if (fault) killed <= 1'b1;
            if (phase == PH_ENER && ctl.tmr_en) begin
                if (pwm_start) begin
                    phase <= PH_HOLD;
                end else if (ms_tick) begin
                    if (cnt + 9'd1 >= limit) phase <= PH_HOLD;
                    else                     cnt   <= cnt + 9'd1;
                end
            end
        end
    end

    assign gate = (phase != PH_IDLE) && !killed &&
                  (!ctl.tmr_en || phase == PH_ENER ||
                   (phase == PH_HOLD && hold_on(ctl.duty, slot)));

    // R1: an on-bit of 0 turns the gate off from the next edge
    a_r1_off_when_low: assert property (@(posedge clk) disable iff (rst)
        !data |=> !gate);

    // R11: a forced-off channel stays off while its on-bit is held
    a_r11_kill_sticks: assert property (@(posedge clk) disable iff (rst)
        (killed && data) |=> !gate);

    // R8: a channel in hold never returns to energizing without a new rise
    a_r8_no_reenergize: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && data) |=> (phase != PH_ENER));

    // R3: the ms counter never passes the longest energizing time
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt < 9'd300);

endmodule

// File: rtl/hold_pwm_seq.sv
module hold_pwm_seq
    import hpwm_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int CLK_HZ  = 100_000_000,
    parameter int SLOT_HZ = 400_000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [7:0]     ctl_reg,
    input  logic [NCH-1:0] chan_on,
    input  logic           pwm_start,
    input  logic           out_en,
    input  logic [NCH-1:0] fault,
    output logic [NCH-1:0] gate
);
    localparam int SLOT_DIV = CLK_HZ / SLOT_HZ;
    localparam int MS_SLOTS = SLOT_HZ / 1000;

    ctl_t              ctl;
    logic              ms_tick;
    logic [SLOT_W-1:0] slot;
    logic [NCH-1:0]    gate_raw;

    assign ctl = ctl_t'(ctl_reg);

    hpwm_tick #(
        .SLOT_DIV (SLOT_DIV),
        .MS_SLOTS (MS_SLOTS)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .ms_tick (ms_tick),
        .slot    (slot)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hpwm_chan u_ch (
            .clk       (clk),
            .rst       (rst),
            .ctl       (ctl),
            .data      (chan_on[i]),
            .pwm_start (pwm_start),
            .ms_tick   (ms_tick),
            .slot      (slot),
            .fault     (fault[i]),
            .gate      (gate_raw[i])
        );
    end

    assign gate = gate_raw & {NCH{out_en}};

endmodule

// File: tb/sim_hold_pwm_seq.sv
module sim_hold_pwm_seq;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [7:0]     ctl_reg = 8'h00;
    logic [NCH-1:0] chan_on = '0;
    logic           pwm_start = 1'b0;
    logic           out_en = 1'b1;
    logic [NCH-1:0] fault = '0;
    logic [NCH-1:0] gate;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NCH-1:0] exp;
        string          tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    // bench rates: slot = 2 cycles, ms = 8 cycles
    hold_pwm_seq #(.NCH(NCH), .CLK_HZ(8000), .SLOT_HZ(4000)) u0 (
        .clk(clk), .rst(rst), .ctl_reg(ctl_reg), .chan_on(chan_on),
        .pwm_start(pwm_start), .out_en(out_en), .fault(fault), .gate(gate)
    );

    // monitor: compares gate against the scoreboard away from the edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (gate !== e.exp) begin
                errors++;
                $display("FAIL %s: gate=%h expected=%h", e.tag, gate, e.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_now(input logic [NCH-1:0] m, input string tag);
        exp_t e;
        e.exp = m;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure(input int ch, input int n, output int hi, output int rises);
        logic prev;
        hi = 0;
        rises = 0;
        @(negedge clk);
        prev = gate[ch];
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gate[ch]) hi++;
            if (gate[ch] && !prev) rises++;
            prev = gate[ch];
        end
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi, rs;
        tick(4);
        rst = 1'b0;
        tick(1);
        exp_now('0, "R1 reset state");

        // R2: timer disabled holds the gate full on
        ctl_reg = 8'h00;
        chan_on = 8'h01;
        tick(1);
        for (int i = 0; i < 40; i++) exp_now(8'h01, "R2 full on");
        chan_on = 8'h00;
        tick(1);
        exp_now('0, "R1 off after bit cleared");

        // R3: code 1 = 3 ms, duty 0 turns off afterwards
        ctl_reg = 8'h81;
        chan_on = 8'h01;
        tick(1);
        for (int i = 0; i < 16; i++) exp_now(8'h01, "R3 energizing 3ms");
        tick(10);
        exp_now('0, "R3 off after 3ms duty 0 (R5)");

        // R3: code 4 = 15 ms
        chan_on = 8'h00;
        ctl_reg = 8'h84;
        tick(1);
        chan_on = 8'h01;
        tick(1);
        for (int i = 0; i < 112; i++) exp_now(8'h01, "R3 energizing 15ms");
        tick(10);
        exp_now('0, "R3 off after 15ms");

        // R9: a new rise restarts energizing
        chan_on = 8'h00;
        tick(1);
        chan_on = 8'h01;
        tick(1);
        exp_now(8'h01, "R9 restart on rise");
        for (int i = 0; i < 12; i++) exp_now(8'h01, "R9 restart holds");

        // R4: code 0 goes straight to hold; duty 0 never turns on
        chan_on = 8'h00;
        ctl_reg = 8'h80;
        tick(1);
        chan_on = 8'h01;
        tick(1);
        for (int i = 0; i < 10; i++) exp_now('0, "R4 direct hold duty 0");

        // R5 / R6: duty and chop period straight from hold
        for (int d = 7; d >= 1; d--) begin
            int exp_hi, exp_rs;
            chan_on = 8'h00;
            tick(1);
            ctl_reg = {1'b1, 3'(d), 4'd0};
            chan_on = 8'h01;
            tick(2);
            measure(0, 64, hi, rs);
            exp_hi = (d >= 3) ? d * 8 : (d == 2 ? 16 : 8);
            exp_rs = (d >= 3) ? 4 : (d == 2 ? 2 : 1);
            check_val($sformatf("R5 high samples duty %0d (R4)", d), hi, exp_hi);
            check_val($sformatf("R6 chop periods duty %0d", d), rs, exp_rs);
        end

        // R7: early exit from a 300 ms energize
        chan_on = 8'h00;
        ctl_reg = 8'hBF;
        tick(1);
        chan_on = 8'h01;
        tick(1);
        for (int i = 0; i < 20; i++) exp_now(8'h01, "R7 energizing");
        pwm_start = 1'b1;
        tick(1);
        pwm_start = 1'b0;
        measure(0, 64, hi, rs);
        check_val("R7 early hold duty 3", hi, 24);

        // R8: pwm_start after expiry is ignored
        chan_on = 8'h00;
        ctl_reg = 8'hF1;
        tick(1);
        chan_on = 8'h01;
        tick(40);
        pwm_start = 1'b1;
        tick(1);
        pwm_start = 1'b0;
        measure(0, 64, hi, rs);
        check_val("R8 hold unchanged after late pwm_start", hi, 56);

        // R10: global disable
        ctl_reg = 8'h00;
        chan_on = 8'hFF;
        tick(1);
        exp_now(8'hFF, "R2 all channels on");
        out_en = 1'b0;
        exp_now('0, "R10 out_en low");
        out_en = 1'b1;
        exp_now(8'hFF, "R10 out_en restored");

        // R11: fault kill is sticky until rewrite
        fault = 8'h04;
        tick(1);
        fault = 8'h00;
        for (int i = 0; i < 5; i++) exp_now(8'hFB, "R11 killed channel stays off");
        chan_on = 8'hFB;
        tick(1);
        chan_on = 8'hFF;
        tick(1);
        exp_now(8'hFF, "R11 rewrite clears kill");

        // R12: independent channel timers
        chan_on = 8'h00;
        ctl_reg = 8'h81;
        tick(1);
        chan_on = 8'h01;
        tick(12);
        chan_on = 8'h03;
        tick(16);
        exp_now(8'h02, "R12 ch0 expired, ch1 energizing");
        tick(10);
        exp_now(8'h00, "R12 both expired");

        chan_on = 8'h00;
        tick(1);
        exp_now('0, "R1 all off at end");

        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule